// File: doc/BRIEF.md
# Video DRAM Cycle Decoder

This block watches the strobe and control pins of a multiport video DRAM model and works out what kind of random-access cycle is being run. All pins are sampled on a free-running clock. The block finds the falling edges of the row and column strobes by comparing each pin with its value from the previous clock. At a row-strobe fall it looks at the column strobe, the transfer gate, the two byte write-enables and the special-function pin. Refresh, transfer and reserved cycles are classified there and then. For ordinary write and register-load cycles the final class waits for the first column-strobe fall, where the special-function pin is read a second time.

The decoded class is a one-hot vector held in a register. Three pieces of mode state sit beside it, and they persist across cycles: the persistent write-per-bit flag, the stop-point enable flag and a 4-bit stop-point code. Only the option-reset refresh clears the two flags. The memory array, the refresh address counter and the serial side are not part of this block.

Top module: `vram_cycle_decoder`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `cyc_type` is 12'h001 (the idle class, bit 0). `cyc_err`, `pwpb_on`, `stop_on` and `stop_code` are all zero.
- R2: `cyc_type` always has exactly one bit set. The bit positions are: 0 idle/pending, 1 transfer, 2 reserved, 3 refresh with stop-point set, 4 refresh with option reset, 5 refresh with no reset, 6 masked write, 7 nonmasked write, 8 masked block write, 9 nonmasked block write, 10 write-mask load, 11 colour load. The register changes only on the clock edge that sees a row-strobe fall or a decoding column-strobe fall, and it shows the new class from the following cycle on.
- R3: The merged write-enable counts as low when `wel_n` or `weu_n` (or both) is low. It counts as high only when both are high.
- R4: If `cas_n` is already low when `ras_n` falls, the cycle is a refresh. The merged write-enable and `dsf` pick the class as follows: low/low gives bit 2, low/high gives bit 3, high/low gives bit 4, high/high gives bit 5.
- R5: If `cas_n` is high and `trg_n` is low when `ras_n` falls, the class becomes bit 1. No column-strobe fall in that row cycle changes it.
- R6: If `cas_n` and `trg_n` are high and `dsf` is low at the row fall, the class becomes bit 0 at the row fall. At the first column fall it becomes 6 + (write-enable high ? 1 : 0) + (`dsf` at column fall ? 2 : 0).
- R7: If `cas_n`, `trg_n`, the write-enable and `dsf` are all high at the row fall, the class at the first column fall is bit 10 when `dsf` is low there and bit 11 when it is high. A bit-10 cycle sets `pwpb_on`.
- R8: A reserved cycle has class bit 2. That covers the refresh case of R4, and also `cas_n` high, `trg_n` high, write-enable low with `dsf` high. `cyc_err` is then high for exactly one cycle, and the mode flags and code do not change.
- R9: A stop-point-set refresh loads `stop_code` from `addr[7:4]` and sets `stop_on`. Address bits 3..0 and 8 have no effect on the code.
- R10: An option-reset refresh clears `pwpb_on` and `stop_on` and leaves `stop_code` as it was. A no-reset refresh changes none of the three.
- R11: Only the first column fall of a row cycle decodes. Later column falls in the same row cycle, and column falls while `ras_n` is high, have no effect. If `ras_n` rises before any column fall, the class stays at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| trg_n | input | 1 | Transfer gate / output enable, active low |
| wel_n | input | 1 | Lower byte write-enable, active low |
| weu_n | input | 1 | Upper byte write-enable, active low |
| dsf | input | 1 | Special-function select |
| addr | input | 9 | Multiplexed address pins |
| cyc_type | output | 12 | One-hot cycle class |
| cyc_err | output | 1 | One-cycle pulse on a reserved combination |
| pwpb_on | output | 1 | Persistent write-per-bit flag |
| stop_on | output | 1 | Stop-point mode flag |
| stop_code | output | 4 | Captured stop-point code |

## Verification
The bench sweeps every combination of the two byte enables and `dsf` for refresh cycles, and every combination of the byte enables and both `dsf` samples for non-refresh cycles. Each result is checked against an arithmetic class index. Getting the write-enable merge backwards would show up as swapped masked and nonmasked classes whenever only one byte enable is low. Reading `dsf` at the wrong strobe would swap write with block write, or mask load with colour load. The bench repeats a column fall inside the same row cycle with `dsf` flipped, and a decoder that re-decodes would change class there. It also checks that the sticky flags survive the no-reset refresh and the reserved cycles, and that the stop-point code ignores its don't-care address bits. A design that cleared on the wrong refresh variant, or took the wrong address nibble, would give wrong flag or code values.

// File: rtl/vram_cyc_pkg.sv
package vram_cyc_pkg;

  localparam int NTYPE = 12;

  localparam int T_IDLE     = 0;
  localparam int T_XFER     = 1;
  localparam int T_RSVD     = 2;
  localparam int T_REF_STOP = 3;
  localparam int T_REF_CLR  = 4;
  localparam int T_REF_KEEP = 5;
  localparam int T_WR_MASK  = 6;
  localparam int T_WR_FULL  = 7;
  localparam int T_BLK_MASK = 8;
  localparam int T_BLK_FULL = 9;
  localparam int T_LD_WMASK = 10;
  localparam int T_LD_COLOR = 11;

  typedef logic [NTYPE-1:0] cyc_vec_t;

  // one-hot vector with bit idx set
  function automatic cyc_vec_t cyc_onehot(input int idx);
    cyc_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // merged write-enable: 1 means high (no byte enabled)
  function automatic logic we_high(input logic wl_n, input logic wu_n);
    return wl_n & wu_n;
  endfunction

  // refresh variant chosen by write-enable and special-function level
  function automatic cyc_vec_t cbr_kind(input logic we_hi, input logic sf);
    case ({we_hi, sf})
      2'b00:   return cyc_onehot(T_RSVD);
      2'b01:   return cyc_onehot(T_REF_STOP);
      2'b10:   return cyc_onehot(T_REF_CLR);
      default: return cyc_onehot(T_REF_KEEP);
    endcase
  endfunction

  // final class at the first column fall of a pending cycle
  function automatic cyc_vec_t col_kind(input logic we_hi, input logic sf_row,
                                        input logic sf_col);
    if (sf_row)
      return sf_col ? cyc_onehot(T_LD_COLOR) : cyc_onehot(T_LD_WMASK);
    case ({sf_col, we_hi})
      2'b00:   return cyc_onehot(T_WR_MASK);
      2'b01:   return cyc_onehot(T_WR_FULL);
      2'b10:   return cyc_onehot(T_BLK_MASK);
      default: return cyc_onehot(T_BLK_FULL);
    endcase
  endfunction

endpackage

// File: rtl/vram_strobe_edges.sv
module vram_strobe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  output logic row_fall,
  output logic row_rise,
  output logic col_fall
);
  logic ras_q, cas_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
    end
  end

  assign row_fall = ras_q & ~ras_n;
  assign row_rise = ~ras_q & ras_n;
  assign col_fall = cas_q & ~cas_n;
endmodule

// File: rtl/vram_cyc_classify.sv
module vram_cyc_classify
  import vram_cyc_pkg::*;
(
  input  logic     cas_n,
  input  logic     trg_n,
  input  logic     we_hi,
  input  logic     sf_now,
  input  logic     we_hi_r,
  input  logic     sf_row_r,
  output cyc_vec_t row_kind,
  output logic     row_pend,
  output cyc_vec_t col_kind_o
);
  always_comb begin
    row_pend = 1'b0;
    if (!cas_n) begin
      row_kind = cbr_kind(we_hi, sf_now);
    end else if (!trg_n) begin
      row_kind = cyc_onehot(T_XFER);
    end else if (sf_now && !we_hi) begin
      row_kind = cyc_onehot(T_RSVD);
    end else begin
      row_kind = cyc_onehot(T_IDLE);
      row_pend = 1'b1;
    end
  end

  assign col_kind_o = col_kind(we_hi_r, sf_row_r, sf_now);
endmodule

// File: rtl/vram_mode_regs.sv
module vram_mode_regs #(
  parameter int STOP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stop,
  input  logic              clr_modes,
  input  logic              set_pwpb,
  input  logic [STOP_W-1:0] code_in,
  output logic              pwpb_on,
  output logic              stop_on,
  output logic [STOP_W-1:0] stop_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwpb_on <= 1'b0;
      stop_on <= 1'b0;
    end else if (clr_modes) begin
      pwpb_on <= 1'b0;
      stop_on <= 1'b0;
    end else begin
      if (set_pwpb) pwpb_on <= 1'b1;
      if (set_stop) stop_on <= 1'b1;
    end
  end

  for (genvar b = 0; b < STOP_W; b++) begin : g_code
    always_ff @(posedge clk) begin
      if (!rst_n)        stop_code[b] <= 1'b0;
      else if (set_stop) stop_code[b] <= code_in[b];
    end
  end
endmodule

// File: rtl/vram_cycle_decoder.sv
module vram_cycle_decoder
  import vram_cyc_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int STOP_LSB = 4,
  parameter int STOP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              trg_n,
  input  logic              wel_n,
  input  logic              weu_n,
  input  logic              dsf,
  input  logic [ADDR_W-1:0] addr,
  output logic [NTYPE-1:0]  cyc_type,
  output logic              cyc_err,
  output logic              pwpb_on,
  output logic              stop_on,
  output logic [STOP_W-1:0] stop_code
);
  localparam int STOP_MSB = STOP_LSB + STOP_W - 1;
  localparam logic [ADDR_W-1:0] STOP_MASK =
    ADDR_W'(((1 << STOP_W) - 1) << STOP_LSB);

  logic     row_fall, row_rise, col_fall, col_take;
  logic     we_hi, we_hi_r, sf_row_r, pend;
  logic     row_pend;
  cyc_vec_t row_kind, col_kind_w;
  logic     addr_unused;

  assign we_hi       = we_high(wel_n, weu_n);
  assign addr_unused = ^(addr & ~STOP_MASK);

  vram_strobe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .row_fall(row_fall), .row_rise(row_rise), .col_fall(col_fall)
  );

  vram_cyc_classify u_cls (
    .cas_n(cas_n), .trg_n(trg_n), .we_hi(we_hi), .sf_now(dsf),
    .we_hi_r(we_hi_r), .sf_row_r(sf_row_r),
    .row_kind(row_kind), .row_pend(row_pend), .col_kind_o(col_kind_w)
  );

  assign col_take = col_fall & pend & ~ras_n & ~row_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_type <= cyc_onehot(T_IDLE);
      cyc_err  <= 1'b0;
      pend     <= 1'b0;
      we_hi_r  <= 1'b1;
      sf_row_r <= 1'b0;
    end else begin
      cyc_err <= 1'b0;
      if (row_fall) begin
        cyc_type <= row_kind;
        cyc_err  <= row_kind[T_RSVD];
        pend     <= row_pend;
        we_hi_r  <= we_hi;
        sf_row_r <= dsf;
      end else if (col_take) begin
        cyc_type <= col_kind_w;
        pend     <= 1'b0;
      end else if (row_rise) begin
        pend <= 1'b0;
      end
    end
  end

  vram_mode_regs #(.STOP_W(STOP_W)) u_modes (
    .clk(clk), .rst_n(rst_n),
    .set_stop(row_fall & row_kind[T_REF_STOP]),
    .clr_modes(row_fall & row_kind[T_REF_CLR]),
    .set_pwpb(col_take & col_kind_w[T_LD_WMASK]),
    .code_in(addr[STOP_MSB:STOP_LSB]),
    .pwpb_on(pwpb_on), .stop_on(stop_on), .stop_code(stop_code)
  );
endmodule

// File: rtl/vram_cycle_chk.sv
module vram_cycle_chk
  import vram_cyc_pkg::*;
#(
  parameter int STOP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NTYPE-1:0]  cyc_type,
  input logic              cyc_err,
  input logic              pwpb_on,
  input logic              stop_on,
  input logic [STOP_W-1:0] stop_code,
  input logic              row_fall,
  input logic              col_take
);
  AST_TYPE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(cyc_type) == 1); // R2
  AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!row_fall && !col_take) |=> $stable(cyc_type)); // R2
  AST_ERR_CLASS: assert property (@(posedge clk) disable iff (!rst_n) cyc_err |-> cyc_type[T_RSVD]); // R8
  AST_ERR_NOSTATE: assert property (@(posedge clk) disable iff (!rst_n) cyc_err |-> ($stable(pwpb_on) && $stable(stop_on) && $stable(stop_code))); // R8
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) cyc_err |=> !cyc_err); // R8
  AST_PWPB_SET: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwpb_on) |-> cyc_type[T_LD_WMASK]); // R7
  AST_STOP_SET: assert property (@(posedge clk) disable iff (!rst_n) $rose(stop_on) |-> cyc_type[T_REF_STOP]); // R9
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) ($fell(pwpb_on) || $fell(stop_on)) |-> cyc_type[T_REF_CLR]); // R10
  AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(stop_code) |-> cyc_type[T_REF_STOP]); // R9
endmodule

bind vram_cycle_decoder vram_cycle_chk #(.STOP_W(STOP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .cyc_err(cyc_err),
  .pwpb_on(pwpb_on), .stop_on(stop_on), .stop_code(stop_code),
  .row_fall(row_fall), .col_take(col_take)
);

// File: tb/vram_cycle_decoder_tb.sv
module vram_cycle_decoder_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, trg_n = 1'b1, wel_n = 1'b1, weu_n = 1'b1, dsf = 1'b0;
  logic [8:0]  addr = '0;
  logic [11:0] cyc_type;
  logic        cyc_err, pwpb_on, stop_on;
  logic [3:0]  stop_code;

  int total = 0, bad = 0;
  logic m_pwpb = 0, m_stop = 0;
  logic [3:0] m_code = 0;

  always #(CLK_P/2) clk = ~clk;

  vram_cycle_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n),
    .wel_n(wel_n), .weu_n(weu_n), .dsf(dsf), .addr(addr),
    .cyc_type(cyc_type), .cyc_err(cyc_err), .pwpb_on(pwpb_on),
    .stop_on(stop_on), .stop_code(stop_code)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_modes(input string req);
    check(req, {31'd0, pwpb_on}, {31'd0, m_pwpb});
    check(req, {31'd0, stop_on}, {31'd0, m_stop});
    check(req, {28'd0, stop_code}, {28'd0, m_code});
  endtask

  task automatic end_cycle();
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b1; trg_n = 1'b1; dsf = 1'b0;
    wel_n = 1'b1; weu_n = 1'b1;
    @(negedge clk);
  endtask

  // R3: write-enable high only when both byte enables are high
  function automatic int we_h(input logic l, input logic u);
    return (l == 1'b1 && u == 1'b1) ? 1 : 0;
  endfunction

  // R4 index: low/low 2, low/high 3, high/low 4, high/high 5
  task automatic cbr_cycle(input logic l, input logic u, input logic s, input logic [8:0] a);
    int idx;
    idx = 2 + 2 * we_h(l, u) + int'(s);
    if (we_h(l, u) == 0 && s == 1'b0) idx = 2;
    @(negedge clk); cas_n = 1'b0;
    @(negedge clk); ras_n = 1'b0; wel_n = l; weu_n = u; dsf = s; addr = a;
    @(negedge clk);
    check("R4/R3 refresh class", cyc_type, 1 << idx);
    check("R8 error pulse", {31'd0, cyc_err}, (idx == 2) ? 1 : 0);
    if (idx == 3) begin m_stop = 1'b1; m_code = a[7:4]; end
    if (idx == 4) begin m_pwpb = 1'b0; m_stop = 1'b0; end
    check_modes((idx == 3) ? "R9 stop set" : (idx == 4) ? "R10 option reset" : "R10/R8 modes kept");
    end_cycle();
    check("R8 error single", {31'd0, cyc_err}, 0);
  endtask

  task automatic dram_cycle(input logic l, input logic u, input logic sr, input logic sc);
    int idx;
    logic rsv;
    rsv = (sr == 1'b1 && we_h(l, u) == 0);
    @(negedge clk); ras_n = 1'b0; wel_n = l; weu_n = u; dsf = sr;
    @(negedge clk);
    check(rsv ? "R8 reserved class" : "R6 pending class", cyc_type, rsv ? 4 : 1);
    check("R8 error pulse", {31'd0, cyc_err}, rsv ? 1 : 0);
    if (rsv) idx = 2;
    else if (sr) idx = 10 + int'(sc);
    else idx = 6 + we_h(l, u) + 2 * int'(sc);
    @(negedge clk); cas_n = 1'b0; dsf = sc;
    @(negedge clk);
    check(rsv ? "R8 reserved kept" : (sr ? "R7 load class" : "R6/R3 write class"), cyc_type, 1 << idx);
    if (idx == 10) m_pwpb = 1'b1;
    check_modes(idx == 10 ? "R7 pwpb set" : "R8/R6 modes");
    // second column fall in same row cycle
    @(negedge clk); cas_n = 1'b1;
    @(negedge clk); cas_n = 1'b0; dsf = ~sc;
    @(negedge clk);
    check("R11 repeat column fall", cyc_type, 1 << idx);
    end_cycle();
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset type", cyc_type, 1);
    check("R1 reset err", {31'd0, cyc_err}, 0);
    check_modes("R1 reset modes");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", cyc_type, 1);

    // R6/R7/R8/R3: full sweep of non-refresh DRAM cycles
    for (int v = 0; v < 16; v++) dram_cycle(v[0], v[1], v[2], v[3]);

    // R4/R9/R10: full sweep of refresh variants
    for (int v = 0; v < 8; v++) cbr_cycle(v[0], v[1], v[2], 9'(37 * v + 21));

    // R9: stop code takes addr[7:4] only
    for (int c = 0; c < 16; c++) cbr_cycle(1'b0, 1'b1, 1'b1, {c[0], c[3:0], ~c[3:0]});
    dram_cycle(1'b1, 1'b1, 1'b1, 1'b0);     // R7 mask load again
    cbr_cycle(1'b1, 1'b1, 1'b1, 9'h0F0);    // R10 no-reset keeps all
    cbr_cycle(1'b0, 1'b0, 1'b0, 9'h0A0);    // R8 reserved keeps all
    cbr_cycle(1'b1, 1'b1, 1'b0, 9'h050);    // R10 option reset, code held

    // R5: transfer cycle ignores column fall
    @(negedge clk); ras_n = 1'b0; trg_n = 1'b0;
    @(negedge clk);
    check("R5 transfer class", cyc_type, 2);
    cas_n = 1'b0; dsf = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R5 transfer held", cyc_type, 2);
    end_cycle();

    // R11: row rises before any column fall; column fall with row high
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk);
    end_cycle();
    @(negedge clk); cas_n = 1'b0; dsf = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 no column decode", cyc_type, 1);
    check_modes("R11 modes untouched");
    cas_n = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule